// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets a clocked host read and write single bytes in an asynchronous 512K x 8 static RAM. The RAM has active-low chip select, write enable and output enable strobes, a 19-bit address and an 8-bit data path. The two highest address bits pick one of four internal banks, and the controller passes all 19 bits straight through. The host offers a request with a valid/ready handshake that carries an address, a write flag and write data. The controller then runs the strobe sequence for one access and marks its end with a one-cycle done pulse. On a read, the captured byte is returned alongside that pulse.

Every timing phase is held for a whole number of clock cycles. The controller works each count out at elaboration by rounding up the speed grade's nanosecond minimum divided by the clock period. This covers address access time, write pulse width, data setup before the end of the write, and write recovery. The data bus is split at the block edge into an output value, a drive enable and an input value, so that a pad cell or a bench model can resolve it.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While reset is held and after it is released, reqReady is 1, sramCsN, sramWeN and sramOeN are 1, sramDqOe is 0 and done is 0, until a request is accepted. A request presented during reset causes no strobe activity.
- R2: A request is accepted on a rising edge where reqValid and reqReady are both 1. reqReady is 0 from the cycle after acceptance up to and including the last cycle of the access.
- R3: A write lowers sramCsN and sramWeN together in the cycle after acceptance. Both stay low for exactly WP_CYC cycles, where WP_CYC is the larger of ceil(tWP/clk) and ceil(tDW/clk). sramAddr and sramDqOut do not change during this overlap.
- R4: sramOeN stays 1 in every cycle where sramWeN is 0.
- R5: After the write overlap, the strobes return high for REC_CYC = ceil(tWR/clk) cycles while address and data are held. done is 1 in the following cycle, which is WP_CYC+REC_CYC+1 cycles after acceptance.
- R6: A read lowers sramCsN and sramOeN together, with sramWeN high, for exactly ACC_CYC = ceil(tAA/clk) cycles. rdData takes sramDqIn as sampled on the edge that ends the last of these cycles.
- R7: After a read, there is one cycle with all strobes high. Then done is 1 for exactly one cycle, ACC_CYC+2 cycles after acceptance, with rdData valid. rdData holds until the next read completes.
- R8: sramDqOe is 1 only during the write overlap and write recovery, and never while sramOeN is 0. At least one cycle with sramDqOe at 0 separates the last driven cycle from a following fall of sramOeN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Controller idle, accepts a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 19 | Byte address |
| reqWdata | input | 8 | Write data |
| done | output | 1 | One-cycle end-of-access pulse |
| rdData | output | 8 | Last read byte |
| sramAddr | output | 19 | RAM address |
| sramCsN | output | 1 | RAM chip select, active low |
| sramWeN | output | 1 | RAM write enable, active low |
| sramOeN | output | 1 | RAM output enable, active low |
| sramDqOut | output | 8 | Data driven toward the RAM |
| sramDqOe | output | 1 | Drive enable for sramDqOut |
| sramDqIn | input | 8 | Data returned from the RAM |

## Verification
The bench builds the controller with a 10 ns clock and the fastest grade's minimums: 70 ns access, 55 ns write pulse, 30 ns data setup and 5 ns recovery. These give counts of 7, 6, 3 and 1. Because the data setup count lies below the pulse count, the pulse width sets the overlap. Because recovery is a single cycle, a read accepted on the done cycle of a write falls right at the edge of the turnaround gap. The RAM model withholds valid data until the output-enable count reaches the access count, so a capture one cycle early returns wrong data. The addresses used cover all four banks, which share the same low bits.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WPULSE,
    ST_WREC,
    ST_RACC,
    ST_REND
  } seqState_t;

  // Strobes handed from control to datapath
  typedef struct packed {
    logic csN;
    logic weN;
    logic oeN;
    logic busDrive;
    logic loadReq;
    logic capture;
  } strobes_t;

  // Round a nanosecond minimum up to whole clocks, at least one
  function automatic int cycCeil(input int ns, input int clkNs);
    int c;
    c = (ns + clkNs - 1) / clkNs;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_seq_pkg::*;
#(
  parameter int ACC_CYC = 7,
  parameter int WP_CYC  = 6,
  parameter int REC_CYC = 1
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     reqWrite,
  output logic     reqReady,
  output logic     done,
  output strobes_t strb
);

  localparam int MAX_CYC = (ACC_CYC > WP_CYC) ? ((ACC_CYC > REC_CYC) ? ACC_CYC : REC_CYC)
                                              : ((WP_CYC > REC_CYC) ? WP_CYC : REC_CYC);
  localparam int CNT_W = $clog2(MAX_CYC + 1);

  seqState_t state;
  logic [CNT_W-1:0] cnt;
  logic cntZero;

  assign cntZero  = (cnt == '0);
  assign reqReady = (state == ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (reqValid) begin
          if (reqWrite) begin
            state <= ST_WPULSE;
            cnt   <= CNT_W'(WP_CYC - 1);
          end else begin
            state <= ST_RACC;
            cnt   <= CNT_W'(ACC_CYC - 1);
          end
        end
        ST_WPULSE: if (cntZero) begin
          state <= ST_WREC;
          cnt   <= CNT_W'(REC_CYC - 1);
        end else cnt <= cnt - 1'b1;
        ST_WREC: if (cntZero) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end else cnt <= cnt - 1'b1;
        ST_RACC: if (cntZero) state <= ST_REND;
                 else cnt <= cnt - 1'b1;
        ST_REND: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb          = '{csN: 1'b1, weN: 1'b1, oeN: 1'b1, busDrive: 1'b0, loadReq: 1'b0, capture: 1'b0};
    strb.loadReq  = (state == ST_IDLE) && reqValid;
    strb.capture  = (state == ST_RACC) && cntZero;
    unique case (state)
      ST_WPULSE: begin
        strb.csN      = 1'b0;
        strb.weN      = 1'b0;
        strb.busDrive = 1'b1;
      end
      ST_WREC: strb.busDrive = 1'b1;
      ST_RACC: begin
        strb.csN = 1'b0;
        strb.oeN = 1'b0;
      end
      default: ;
    endcase
  end

  // R3: write enable never falls after chip select
  a_r3_we_with_cs: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strb.weN) |-> $fell(strb.csN));
  // R4: output enable inactive whenever writing
  a_r4_oe_off_in_write: assert property (@(posedge clk) disable iff (!rstN)
    !strb.weN |-> strb.oeN);
  // R7: done is a single-cycle pulse
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R2: accepted request makes the controller busy
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

endmodule

// File: rtl/sram_seq_dpath.sv
module sram_seq_dpath
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] sramDqIn,
  output logic [ADDR_W-1:0] sramAddr,
  output logic              sramCsN,
  output logic              sramWeN,
  output logic              sramOeN,
  output logic [DATA_W-1:0] sramDqOut,
  output logic              sramDqOe,
  output logic [DATA_W-1:0] rdData
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdData <= '0;
    end else begin
      if (strb.loadReq) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (strb.capture) rdData <= sramDqIn;
    end
  end

  assign sramAddr  = addrQ;
  assign sramDqOut = wdataQ;
  assign sramDqOe  = strb.busDrive;
  assign sramCsN   = strb.csN;
  assign sramWeN   = strb.weN;
  assign sramOeN   = strb.oeN;

  // R3: address frozen across the write overlap
  a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!sramCsN && !sramWeN) |=> (sramCsN || sramWeN || $stable(sramAddr)));
  // R5: driven data does not change while the bus is driven
  a_r5_data_hold: assert property (@(posedge clk) disable iff (!rstN)
    (sramDqOe && $past(sramDqOe)) |-> $stable(sramDqOut));
  // R8: never drive while the RAM may drive
  a_r8_no_contention: assert property (@(posedge clk) disable iff (!rstN)
    !sramOeN |-> !sramDqOe);
  // R8: a released cycle precedes any output enable
  a_r8_turnaround: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sramOeN) |-> !$past(sramDqOe));

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W  = 19,
  parameter int DATA_W  = 8,
  parameter int CLK_NS  = 10,
  parameter int T_AA_NS = 70,
  parameter int T_WP_NS = 55,
  parameter int T_DW_NS = 30,
  parameter int T_WR_NS = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] sramAddr,
  output logic              sramCsN,
  output logic              sramWeN,
  output logic              sramOeN,
  output logic [DATA_W-1:0] sramDqOut,
  output logic              sramDqOe,
  input  logic [DATA_W-1:0] sramDqIn
);

  localparam int ACC_CYC = cycCeil(T_AA_NS, CLK_NS);
  localparam int WPP_CYC = cycCeil(T_WP_NS, CLK_NS);
  localparam int DW_CYC  = cycCeil(T_DW_NS, CLK_NS);
  localparam int WP_CYC  = (WPP_CYC > DW_CYC) ? WPP_CYC : DW_CYC;
  localparam int REC_CYC = cycCeil(T_WR_NS, CLK_NS);

  strobes_t strb;

  sram_seq_fsm #(
    .ACC_CYC(ACC_CYC), .WP_CYC(WP_CYC), .REC_CYC(REC_CYC)
  ) i_fsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .done(done), .strb(strb)
  );

  sram_seq_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) i_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .sramDqIn(sramDqIn), .sramAddr(sramAddr), .sramCsN(sramCsN), .sramWeN(sramWeN),
    .sramOeN(sramOeN), .sramDqOut(sramDqOut), .sramDqOe(sramDqOe), .rdData(rdData)
  );

endmodule

// File: tb/test_sram_seq_ctrl.sv
module test_sram_seq_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int ACC = (70 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int WP  = (55 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int REC = (5 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int N_VEC = 12;
  // {write, address, data-or-expected}
  localparam logic [27:0] VEC [N_VEC] = '{
    {1'b1, 19'h00012, 8'hA5}, {1'b1, 19'h20012, 8'h3C},
    {1'b1, 19'h40012, 8'hC3}, {1'b1, 19'h60012, 8'h0F},
    {1'b0, 19'h00012, 8'hA5}, {1'b0, 19'h20012, 8'h3C},
    {1'b0, 19'h40012, 8'hC3}, {1'b0, 19'h60012, 8'h0F},
    {1'b1, 19'h000FF, 8'h00}, {1'b0, 19'h000FF, 8'h00},
    {1'b1, 19'h20012, 8'h99}, {1'b0, 19'h20012, 8'h99}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [18:0] reqAddr = '0;
  logic [7:0] reqWdata = '0;
  logic reqReady, done, sramCsN, sramWeN, sramOeN, sramDqOe;
  logic [7:0] rdData, sramDqOut;
  logic [7:0] sramDqIn = 8'hEE;
  logic [18:0] sramAddr;
  int nChecks = 0, nFail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_seq_ctrl i_sram_seq_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .done(done),
    .rdData(rdData), .sramAddr(sramAddr), .sramCsN(sramCsN), .sramWeN(sramWeN),
    .sramOeN(sramOeN), .sramDqOut(sramDqOut), .sramDqOe(sramDqOe), .sramDqIn(sramDqIn)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural RAM: four banks of 256 bytes indexed by bank bits and low byte
  logic [7:0] mem [1024];
  function automatic int idxOf(input logic [18:0] a);
    return int'({a[18:17], a[7:0]});
  endfunction
  initial for (int i = 0; i < 1024; i++) mem[i] = 8'(i) ^ 8'h5A;

  int ovl = 0, oeCnt = 0, cyc = 0, lastDrive = -100;
  logic prevCs = 1'b1, prevWe = 1'b1, prevOe = 1'b1;
  logic [18:0] ovlAddr = '0;
  logic [7:0] ovlData = '0;

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (!sramCsN && !sramWeN) begin
        if (ovl == 0) begin
          chk(prevCs || !prevWe, "R3 cs before we", 0, 1);
          ovlAddr = sramAddr;
        end else if (sramAddr != ovlAddr) chk(0, "R3 addr moved", int'(sramAddr), int'(ovlAddr));
        if (!sramDqOe) chk(0, "R8 bus off in write", 0, 1);
        ovlData = sramDqOut;
        ovl++;
      end else if (ovl > 0) begin
        chk(ovl == WP, "R3 overlap width", ovl, WP);
        mem[idxOf(ovlAddr)] = ovlData;
        ovl = 0;
      end
      if (!sramWeN && !sramOeN) chk(0, "R4 oe during write", 0, 1);
      if (!sramCsN && !sramOeN && sramDqOe) chk(0, "R8 contention", 1, 0);
      if (sramDqOe) lastDrive = cyc;
      if (prevOe && !sramOeN) chk(cyc - lastDrive >= 2, "R8 turnaround", cyc - lastDrive, 2);
      if (!sramCsN && !sramOeN && sramWeN) oeCnt++; else oeCnt = 0;
      if (oeCnt == 0) sramDqIn = 8'hEE;
      else if (oeCnt >= ACC) sramDqIn = mem[idxOf(sramAddr)];
      else sramDqIn = ~mem[idxOf(sramAddr)];
    end
    prevCs = sramCsN; prevWe = sramWeN; prevOe = sramOeN;
  end

  task automatic doOp(input bit wr, input logic [18:0] a, input logic [7:0] d);
    int lat;
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
    reqWdata = ~d; reqAddr = ~a;  // request fields must already be latched
    lat = 1;
    chk(!reqReady, "R2 busy", int'(reqReady), 0);
    while (!done && lat < 60) begin @(negedge clk); lat++; end
    if (wr) chk(lat == WP + REC + 1, "R5 write latency", lat, WP + REC + 1);
    else begin
      chk(lat == ACC + 2, "R7 read latency", lat, ACC + 2);
      chk(rdData == d, "R6 read data", int'(rdData), int'(d));
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog", 1, 0);
    finish();
  end

  initial begin
    reqValid = 1'b1; reqWrite = 1'b1;  // request during reset
    repeat (3) @(negedge clk);
    chk(reqReady && sramCsN && sramWeN && sramOeN && !sramDqOe && !done, "R1 reset outputs",
        {reqReady, sramCsN, sramWeN, sramOeN, sramDqOe, done}, 6'b111100);
    reqValid = 1'b0;
    @(negedge clk); rstN = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk(sramCsN && sramWeN && sramOeN && !sramDqOe && !done && reqReady, "R1 idle after reset",
          {sramCsN, sramWeN, sramOeN, sramDqOe}, 4'b1110);
    end
    for (int v = 0; v < N_VEC; v++) doOp(VEC[v][27], VEC[v][26:8], VEC[v][7:0]);
    // R7: done single pulse and rdData held until the next read
    @(negedge clk);
    chk(!done, "R7 done one cycle", int'(done), 0);
    doOp(1'b1, 19'h40033, 8'h11);
    chk(rdData == 8'h99, "R7 rdData held", int'(rdData), 8'h99);
    // R6: unwritten location returns the RAM's content
    doOp(1'b0, 19'h00077, 8'h2D);
    // R8: read accepted on the done cycle of a write
    doOp(1'b1, 19'h60044, 8'h5E);
    doOp(1'b0, 19'h60044, 8'h5E);
    repeat (3) @(negedge clk);
    chk(sramCsN && sramOeN && !sramDqOe && reqReady, "R1 idle between requests",
        {sramCsN, sramOeN, sramDqOe}, 3'b110);
    finish();
  end

endmodule